// File: doc/BRIEF.md
# Rolling Activate Window Limiter

This block sits next to a DRAM command scheduler and keeps the row-activate rate within the device limit. That limit allows no more than four activates inside any sliding window of a programmable number of controller cycles. Each cycle the block watches a one-cycle strobe that marks an issued activate. It keeps the issue times of the four most recent activates. It raises an allow flag when one more activate in the current cycle would not put a fifth one inside the window.

The window length is a run-time input and is read in the same cycle it is used. A length of zero turns the limiter off. So does any length no greater than four times the command-bus busy time, since bus spacing alone already meets the rule. The allow flag is formed without a register from the stored history, so the scheduler can act on it in the cycle it decides.

If a strobe arrives while the flag is low, the block raises a protocol-error flag. That activate is still stored, because the device did receive it.

Top module: `act_window_limiter`

## Requirements
- R1: After reset the history holds no activates, `actAllowed` is 1 and `protoErr` is 0.
- R2: With `windowLen` above the inert limit, `actAllowed` in cycle t is 0 exactly when four activates are stored and the fourth most recent one was issued fewer than `windowLen` cycles before t. An activate issued in cycle t counts from cycle t+1 on.
- R3: With `windowLen` equal to 0, `actAllowed` is always 1, whatever the strobe pattern.
- R4: With `windowLen` from 1 up to four times `BUS_BUSY` (8 by default), `actAllowed` is always 1.
- R5: While fewer than four activates have been issued since reset, `actAllowed` is 1.
- R6: An activate issued more than 2^`WIN_W` - 1 cycles ago never blocks, however long the idle gap (timestamp wraparound is handled).
- R7: `protoErr` is 1 in exactly the cycles where `actIssued` is 1 and `actAllowed` is 0. Such an activate is still stored in the history.
- R8: A change of `windowLen` takes effect on `actAllowed` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low synchronous reset |
| windowLen | input | WIN_W | Window length in controller cycles; 0 disables |
| actIssued | input | 1 | One-cycle strobe: an activate is issued this cycle |
| actAllowed | output | 1 | An activate may be issued this cycle |
| protoErr | output | 1 | An activate was issued while not allowed |

## Verification
A greedy scheduler issues an activate every time the flag allows it. This shows that the block unblocks exactly `windowLen` cycles after the fourth most recent activate, and not one cycle early or late. Strobes on every cycle with window lengths of 0, 8 and 9 find the boundary between the inert range and the active range. The same bursts make the error flag fire, and they show that blocked activates still enter the history. Idle gaps of several hundred cycles check timestamp wraparound. A window that shrinks while the limiter is blocked shows that the new length is used in the same cycle. Evenly spaced activates run against a window that they only just fit.

// File: rtl/act_win_pkg.sv
package act_win_pkg;
  localparam int HIST_DEPTH = 4;
  localparam int SLOT_W = $clog2(HIST_DEPTH);

  typedef struct packed {
    logic              push;
    logic [SLOT_W-1:0] slot;
  } histCtrl_t;
endpackage

// File: rtl/act_win_dpath.sv
module act_win_dpath
  import act_win_pkg::*;
#(
  parameter int WIN_W = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  histCtrl_t     hist,
  output logic          oldestValid,
  output logic [WIN_W:0] oldestAge
);
  localparam int TS_W = WIN_W + 1;
  localparam logic [TS_W-1:0] RETIRE_AGE = TS_W'((1 << WIN_W) - 1);

  logic [TS_W-1:0] nowTs;
  logic [TS_W-1:0] stamp [HIST_DEPTH];
  logic [HIST_DEPTH-1:0] entryValid;

  always_ff @(posedge clk) begin
    if (!rstN) nowTs <= '0;
    else       nowTs <= nowTs + 1'b1;
  end

  // Entries retire just before their age could wrap the timestamp range.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      entryValid <= '0;
      for (int i = 0; i < HIST_DEPTH; i++) stamp[i] <= '0;
    end else begin
      for (int i = 0; i < HIST_DEPTH; i++) begin
        if (hist.push && hist.slot == SLOT_W'(i)) begin
          stamp[i]      <= nowTs;
          entryValid[i] <= 1'b1;
        end else if (entryValid[i] && (nowTs - stamp[i]) >= RETIRE_AGE) begin
          entryValid[i] <= 1'b0;
        end
      end
    end
  end

  assign oldestValid = entryValid[hist.slot];
  assign oldestAge   = nowTs - stamp[hist.slot];
endmodule

// File: rtl/act_win_ctrl.sv
module act_win_ctrl
  import act_win_pkg::*;
#(
  parameter int WIN_W    = 8,
  parameter int BUS_BUSY = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIN_W-1:0] windowLen,
  input  logic             actIssued,
  input  logic             oldestValid,
  input  logic [WIN_W:0]   oldestAge,
  output histCtrl_t        hist,
  output logic             actAllowed,
  output logic             protoErr
);
  localparam int INERT_MAX = HIST_DEPTH * BUS_BUSY;
  localparam logic [WIN_W-1:0] INERT_LIM = WIN_W'(INERT_MAX);

  logic [SLOT_W-1:0] wrPtr;
  logic bypass;

  always_ff @(posedge clk) begin
    if (!rstN)          wrPtr <= '0;
    else if (actIssued) wrPtr <= wrPtr + 1'b1;
  end

  // The slot about to be overwritten holds the oldest of the four stamps.
  assign hist.push  = actIssued;
  assign hist.slot  = wrPtr;
  assign bypass     = (windowLen <= INERT_LIM);
  assign actAllowed = bypass || !oldestValid || (oldestAge >= {1'b0, windowLen});
  assign protoErr   = actIssued && !actAllowed;
endmodule

// File: rtl/act_window_limiter.sv
module act_window_limiter
  import act_win_pkg::*;
#(
  parameter int WIN_W    = 8,
  parameter int BUS_BUSY = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIN_W-1:0] windowLen,
  input  logic             actIssued,
  output logic             actAllowed,
  output logic             protoErr
);
  histCtrl_t       hist;
  logic            oldestValid;
  logic [WIN_W:0]  oldestAge;

  act_win_ctrl #(.WIN_W(WIN_W), .BUS_BUSY(BUS_BUSY)) u_ctrl (
    .clk(clk), .rstN(rstN), .windowLen(windowLen), .actIssued(actIssued),
    .oldestValid(oldestValid), .oldestAge(oldestAge), .hist(hist),
    .actAllowed(actAllowed), .protoErr(protoErr)
  );

  act_win_dpath #(.WIN_W(WIN_W)) u_dpath (
    .clk(clk), .rstN(rstN), .hist(hist),
    .oldestValid(oldestValid), .oldestAge(oldestAge)
  );
endmodule

// File: rtl/act_win_checker.sv
module act_win_checker #(
  parameter int WIN_W    = 8,
  parameter int BUS_BUSY = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic [WIN_W-1:0] windowLen,
  input logic             actIssued,
  input logic             actAllowed,
  input logic             protoErr
);
  localparam logic [WIN_W-1:0] INERT_LIM = WIN_W'(4 * BUS_BUSY);
  logic [2:0] seenActs;
  logic       pastValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seenActs  <= '0;
      pastValid <= 1'b0;
    end else begin
      pastValid <= 1'b1;
      if (actIssued && seenActs != 3'd4) seenActs <= seenActs + 1'b1;
    end
  end

  assert_off_when_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (windowLen == '0) |-> actAllowed);

  assert_inert_short_R4: assert property (@(posedge clk) disable iff (!rstN)
    (windowLen <= INERT_LIM) |-> actAllowed);

  assert_few_acts_R5: assert property (@(posedge clk) disable iff (!rstN)
    (seenActs < 3'd4) |-> actAllowed);

  assert_err_needs_strobe_R7: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |-> actIssued);

  // A new activate can only make the window tighter, so unblocking comes from aging.
  assert_unblock_by_aging_R2: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $rose(actAllowed) && $stable(windowLen)) |-> !$past(actIssued));
endmodule

bind act_window_limiter act_win_checker #(.WIN_W(WIN_W), .BUS_BUSY(BUS_BUSY)) u_chk (
  .clk(clk), .rstN(rstN), .windowLen(windowLen), .actIssued(actIssued),
  .actAllowed(actAllowed), .protoErr(protoErr)
);

// File: tb/tb_act_window_limiter.sv
module tb_act_window_limiter;
  localparam int CLK_PERIOD = 10;
  localparam int WIN_W = 8;
  localparam int BUS_BUSY = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [WIN_W-1:0] windowLen = '0;
  logic actIssued = 1'b0;
  logic actAllowed, protoErr;

  int testsRun = 0;
  int testsFailed = 0;
  int nowCyc = 0;
  int hist[$];
  string phaseTag = "";
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  act_window_limiter #(.WIN_W(WIN_W), .BUS_BUSY(BUS_BUSY)) dut (
    .clk(clk), .rstN(rstN), .windowLen(windowLen), .actIssued(actIssued),
    .actAllowed(actAllowed), .protoErr(protoErr)
  );

  function automatic bit modelAllow(int w);
    if (w == 0) return 1'b1;
    if (w <= 4 * BUS_BUSY) return 1'b1;
    if (hist.size() < 4) return 1'b1;
    return (nowCyc - hist[hist.size()-4]) >= w;
  endfunction

  function automatic string ruleTag(int w);
    if (phaseTag != "") return phaseTag;
    if (w == 0) return "R3";
    if (w <= 4 * BUS_BUSY) return "R4";
    if (hist.size() < 4) return "R5";
    return "R2";
  endfunction

  task automatic check(string tag, bit actual, bit expected, string what);
    testsRun++;
    if (actual !== expected) begin
      testsFailed++;
      $display("FAIL %s %s at cycle %0d: actual %0b expected %0b", tag, what, nowCyc, actual, expected);
    end
  endtask

  // One cycle: drive away from the edge, compare, then update the model.
  task automatic step(bit act, int w);
    bit expAllow;
    @(negedge clk);
    actIssued = act;
    windowLen = WIN_W'(w);
    #1;
    expAllow = modelAllow(w);
    check(ruleTag(w), actAllowed, expAllow, "actAllowed");
    check("R7", protoErr, act && !expAllow, "protoErr");
    if (act) hist.push_back(nowCyc);
    nowCyc++;
  endtask

  task automatic greedy(int n, int w);
    for (int i = 0; i < n; i++) step(modelAllow(w), w);
  endtask

  task automatic burst(int n, int w);
    for (int i = 0; i < n; i++) step(1'b1, w);
  endtask

  task automatic idle(int n, int w);
    for (int i = 0; i < n; i++) step(1'b0, w);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      testsFailed++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", actAllowed, 1'b1, "reset actAllowed");
    check("R1", protoErr, 1'b0, "reset protoErr");
    @(negedge clk);
    rstN = 1'b1;
    check("R1", actAllowed, 1'b1, "post-reset actAllowed");

    phaseTag = "R5";  greedy(4, 20);  phaseTag = "";
    greedy(60, 20);                      // R2 exact unblock timing
    idle(30, 20);
    burst(10, 0);                        // R3
    burst(10, 8);                        // R4
    burst(10, 9);                        // R2 boundary, R7 violations recorded
    greedy(40, 9);
    phaseTag = "R6"; idle(600, 255); burst(6, 255); greedy(300, 255);
    idle(300, 255); burst(3, 255); phaseTag = "";
    idle(300, 50);
    burst(4, 50); idle(25, 50);
    phaseTag = "R8"; step(1'b0, 30); idle(3, 30); step(1'b0, 50); idle(4, 28); phaseTag = "";
    for (int i = 0; i < 12; i++) begin   // evenly spaced activates, window 17
      step(1'b1, 17);
      idle(4, 17);
    end
    greedy(80, 33);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule